// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects nine single-cycle event pulses from the transmit and receive paths of a packet buffer core. Each pulse is latched into a status register and stays there until software clears it. A companion enable register chooses which latched events can raise the interrupt line. The interrupt line is active high.

Software reaches the block through a plain read and write strobe with a byte offset. Status sits at offset 0x0 and uses write-one-to-clear. Enable sits at offset 0x4 and is an ordinary read/write register.

Writing the key value 0x000000A5 to offset 0x28 starts a core-wide reset. That reset drives the link reset output for a fixed number of cycles and returns both registers to their power-up values. Every other offset in the 0x00 to 0x3C window reads as zero from this block, and writes to those offsets change nothing here.

Top module: `irq_ctl_top`

## Requirements
- R1: Event input bit i (0 to 8) sets status bit i. The order is: bit 0 receive length underrun, bit 1 receive packet overrun read, bit 2 receive underrun, bit 3 transmit overrun, bit 4 transmit complete, bit 5 receive complete, bit 6 transmit size error, bit 7 transmit reset done, bit 8 receive reset done.
- R2: A status bit set by a one-cycle pulse stays set in the following cycles after the pulse has ended.
- R3: A write to offset 0x0 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged, and several bits can be cleared in one write.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is 1 exactly when some bit is 1 in both the status register and the enable register.
- R6: After power-on reset, status reads 0x00000180 and enable reads 0x00000180, so `irq_o` is 1.
- R7: A write to offset 0x4 loads enable bits 8..0 from data bits 8..0. Reads of offsets 0x0 and 0x4 return 0 in bits 31..9.
- R8: Reads of offset 0x28 and of the reserved offsets 0x2C, 0x30, 0x34, 0x38 and 0x3C return zero. Writes to the reserved offsets leave status, enable, `irq_o` and `link_rst_o` unchanged.
- R9: Writing 0x000000A5 to offset 0x28 drives `link_rst_o` high from the clock edge that takes the write, for RST_CYCLES (default 4) cycles. While it is high, events and writes have no effect. Afterwards, status and enable hold their R6 values.
- R10: Writing any value other than 0x000000A5 to offset 0x28 leaves `link_rst_o` low and both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe; read data is combinational |
| addr_i | input | 6 | Byte offset of the access (word aligned) |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, zero when no read is active |
| evt_i | input | 9 | Single-cycle event pulses, one per status bit |
| irq_o | output | 1 | Active-high interrupt |
| link_rst_o | output | 1 | Core-wide link reset pulse |

## Verification
The assertions assume three things about the inputs:
- Offsets are word aligned.
- A write and a read are never both strobed in the same cycle.
- Event pulses arriving during a reset are meant to be lost.

The bench keeps to these assumptions. It drives every access on the falling edge, one access at a time, and always at 4-byte offsets. It applies event pulses only outside the reset windows, except for one deliberate pulse during the link reset, which checks that the pulse is discarded.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int NUM_EVT = 9;

    // Event positions; a software driver decodes these bit positions.
    typedef enum int {
        EV_RX_LEN_UNDER = 0,
        EV_RX_OVER_READ = 1,
        EV_RX_UNDER     = 2,
        EV_TX_OVER      = 3,
        EV_TX_DONE      = 4,
        EV_RX_DONE      = 5,
        EV_TX_SIZE_ERR  = 6,
        EV_TX_RST_DONE  = 7,
        EV_RX_RST_DONE  = 8
    } ev_idx_e;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_LINK   = 6'h28;

    localparam logic [DATA_W-1:0] LINK_KEY = 32'h0000_00A5;

    // Decoded request from the simple strobe interface.
    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    function automatic logic [NUM_EVT-1:0] bit_of(input ev_idx_e idx);
        logic [NUM_EVT-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    localparam logic [NUM_EVT-1:0] RST_DONE_MASK =
        bit_of(EV_TX_RST_DONE) | bit_of(EV_RX_RST_DONE);

    function automatic logic [DATA_W-1:0] widen(input logic [NUM_EVT-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NUM_EVT-1:0] = v;
        return w;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int               N      = 9,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);

    logic [N-1:0] status_q;

    // Each bit is its own sticky cell; a set in the same cycle beats a clear.
    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                status_q[i] <= RST_VAL[i];
            end else if (evt_i[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    assign status_o = status_q;

    assert_evt_latched_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    assert_no_spurious_set_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

    assert_w1c_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i != '0) |=> ((status_q & $past(clr_i) & ~$past(evt_i)) == '0));

    assert_zero_keeps_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((status_q ^ $past(status_q)) & ~$past(clr_i) & ~$past(evt_i)) == '0));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int           N       = 9,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q <= RST_VAL;
        end else if (we_i) begin
            en_q <= wdata_i;
        end
    end

    assign en_o = en_q;

    assert_en_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(en_q));

    assert_en_load_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> (en_q == $past(wdata_i)));

endmodule

// File: rtl/link_reset_gen.sv
module link_reset_gen #(
    parameter int RST_CYCLES = 4,
    localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic key_wr_i,
    output logic link_rst_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (key_wr_i) begin
            cnt_q <= CNT_LOAD;
        end
    end

    assign link_rst_o = (cnt_q != '0);

    assert_key_starts_reset_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (key_wr_i && !link_rst_o) |=> link_rst_o);

    assert_cnt_bounded_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CNT_LOAD);

    assert_no_self_start_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!key_wr_i && !link_rst_o) |=> !link_rst_o);

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o,
    output logic               link_rst_o
);

    reg_req_t           req;
    logic               core_rst;
    logic               hit_status, hit_enable, key_wr;
    logic [NUM_EVT-1:0] clr_vec, status, enable;

    assign req = '{wr: wr_en_i, rd: rd_en_i, addr: addr_i, data: wr_data_i};

    assign core_rst   = rst_i | link_rst_o;
    assign hit_status = req.wr && (req.addr == OFF_STATUS);
    assign hit_enable = req.wr && (req.addr == OFF_ENABLE);
    assign key_wr     = req.wr && (req.addr == OFF_LINK) && (req.data == LINK_KEY);
    assign clr_vec    = hit_status ? req.data[NUM_EVT-1:0] : '0;

    irq_status_bank #(
        .N       (NUM_EVT),
        .RST_VAL (RST_DONE_MASK)
    ) u_status (
        .clk_i    (clk_i),
        .rst_i    (core_rst),
        .evt_i    (evt_i),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    irq_enable_reg #(
        .N       (NUM_EVT),
        .RST_VAL (RST_DONE_MASK)
    ) u_enable (
        .clk_i   (clk_i),
        .rst_i   (core_rst),
        .we_i    (hit_enable),
        .wdata_i (req.data[NUM_EVT-1:0]),
        .en_o    (enable)
    );

    link_reset_gen #(
        .RST_CYCLES (RST_CYCLES)
    ) u_link (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .key_wr_i   (key_wr),
        .link_rst_o (link_rst_o)
    );

    assign irq_o = |(status & enable);

    always_comb begin
        rd_data_o = '0;
        if (req.rd) begin
            case (req.addr)
                OFF_STATUS: rd_data_o = widen(status);
                OFF_ENABLE: rd_data_o = widen(enable);
                default:    rd_data_o = '0;
            endcase
        end
    end

    assert_link_clears_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        link_rst_o |=> ((status == RST_DONE_MASK) && (enable == RST_DONE_MASK)));

    assert_irq_tracks_R5: assert property (@(posedge clk_i) disable iff (core_rst)
        ((status & enable) != '0) |-> irq_o);

endmodule

// File: tb/tb_irq_ctl_top.sv
module tb_irq_ctl_top;
    import irq_ctl_pkg::*;

    localparam int RSTC = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0, rdata;
    logic [NUM_EVT-1:0] evt = '0;
    logic               irq, lrst;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [NUM_EVT-1:0] m_st, m_en;

    irq_ctl_top #(.RST_CYCLES(RSTC)) dut (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
        .evt_i(evt), .irq_o(irq), .link_rst_o(lrst)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] v);
        @(negedge clk);
        evt = v;
        @(posedge clk);
        #1 evt = '0;
    endtask

    task automatic check_regs(input string req);
        logic [31:0] d;
        rd(OFF_STATUS, d); chk(req, d, widen(m_st));
        rd(OFF_ENABLE, d); chk(req, d, widen(m_en));
        @(negedge clk);
        chk(req, {31'b0, irq}, {31'b0, |(m_st & m_en)});
        chk(req, {31'b0, lrst}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R6: power-up values
        m_st = RST_DONE_MASK; m_en = RST_DONE_MASK;
        check_regs("R6");

        // R3: clear everything in one write
        wr(OFF_STATUS, 32'hFFFF_FFFF); m_st = '0;
        check_regs("R3");

        // R1/R2: each event sets its own bit and stays set
        for (int i = 0; i < NUM_EVT; i++) begin
            pulse(NUM_EVT'(1) << i);
            m_st = NUM_EVT'(1) << i;
            repeat (3) @(negedge clk);
            rd(OFF_STATUS, d); chk($sformatf("R1 R2 bit%0d", i), d, widen(m_st));
            wr(OFF_STATUS, 32'(1) << i); m_st = '0;
            rd(OFF_STATUS, d); chk($sformatf("R3 bit%0d", i), d, 32'd0);
        end

        // R3: zero bits leave status alone; multi-bit clear
        pulse('1); m_st = '1;
        wr(OFF_STATUS, 32'd0);
        rd(OFF_STATUS, d); chk("R3 zero write", d, widen(m_st));
        wr(OFF_STATUS, 32'h0000_0155); m_st = m_st & ~9'h155;
        rd(OFF_STATUS, d); chk("R3 multi", d, widen(m_st));

        // R4: event beats a simultaneous clear
        @(negedge clk);
        evt = 9'h0AA; wr_en = 1'b1; addr = OFF_STATUS; wdata = 32'h0000_01FF;
        @(posedge clk);
        #1 evt = '0; wr_en = 1'b0;
        m_st = 9'h0AA;
        rd(OFF_STATUS, d); chk("R4", d, widen(m_st));

        // R5/R7: exhaustive sweep of enable against two status patterns
        for (int p = 0; p < 2; p++) begin
            wr(OFF_STATUS, 32'h1FF); m_st = '0;
            if (p == 1) begin pulse(9'h021); m_st = 9'h021; end
            else begin pulse('1); m_st = '1; end
            for (int e = 0; e < 512; e++) begin
                wr(OFF_ENABLE, 32'hFFFF_FE00 | 32'(e)); m_en = NUM_EVT'(e);
                @(negedge clk);
                chk("R5", {31'b0, irq}, {31'b0, |(m_st & m_en)});
                if (e % 64 == 0) begin
                    rd(OFF_ENABLE, d); chk("R7", d, widen(m_en));
                end
            end
        end

        // R8: reserved and link offsets read zero; writes ignored
        for (int a = 'h28; a <= 'h3C; a += 4) begin
            rd(ADDR_W'(a), d); chk("R8 read", d, 32'd0);
        end
        for (int a = 'h2C; a <= 'h3C; a += 4) wr(ADDR_W'(a), LINK_KEY);
        check_regs("R8 write");

        // R10: wrong key ignored
        wr(OFF_LINK, 32'h0000_01A5);
        wr(OFF_LINK, 32'h0000_00A4);
        check_regs("R10");

        // R9: keyed reset pulse, event during it lost
        wr(OFF_STATUS, 32'h1FF); m_st = '0;
        wr(OFF_ENABLE, 32'h0); m_en = '0;
        wr(OFF_LINK, LINK_KEY);
        begin
            int hi;
            hi = 0;
            for (int c = 0; c < RSTC + 3; c++) begin
                @(negedge clk);
                if (lrst) hi++;
                if (c == 1) evt = 9'h010;
                if (c == 2) evt = '0;
            end
            chk("R9 width", 32'(hi), 32'(RSTC));
        end
        m_st = RST_DONE_MASK; m_en = RST_DONE_MASK;
        check_regs("R9 after");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule